// File: doc/BRIEF.md
# Fine-Adjust PTP Time Counter

This block keeps a time-of-day value (seconds plus nanoseconds) for stamping network packets. It runs on the PTP reference clock. Every cycle a 32-bit frequency word, the addend, is added into a 32-bit phase accumulator. The nanoseconds count moves forward by a programmed step only on cycles where that addition wraps past 2^32. The ratio addend / 2^32 therefore sets how often the step is applied. Software can trim the clock rate in very small amounts by changing the addend, and the step size stays fixed.

The step is normally set to twice the clock period. At that setting a nominal clock needs an addend near 0x80000000, and the accumulator wraps about every other cycle. That leaves headroom both ways for frequency correction. If the step were smaller than the clock period, even the largest addend could not keep pace with real time. A load strobe sets the seconds and nanoseconds and clears the accumulator in the same edge. A capture strobe copies the running time into holding registers so that both fields can be read as one consistent pair.

Top module: `ptp_fine_clock`

## Requirements
- R1: While reset is held, the live time (`sec_o`, `ns_o`) and the captured time (`snap_sec_o`, `snap_ns_o`) all read zero after the next edge, and the accumulator holds zero.
- R2: At every edge the accumulator adds `addend_i` modulo 2^32. The time advances by `incr_i` nanoseconds only on an edge where that addition wraps, and holds otherwise. Starting from a cleared accumulator, after N edges whose addends sum to S, the time has advanced by floor(S / 2^32) × `incr_i` ns.
- R3: When nanoseconds plus the step reaches 1,000,000,000 or more, the nanoseconds become (ns + step − 1,000,000,000) and the seconds increase by one. `ns_o` is always below 1,000,000,000.
- R4: The seconds field is 32 bits wide and wraps from 0xFFFFFFFF to 0 on a carry.
- R5: When `load_i` is high at an edge, the time after that edge equals `load_sec_i`/`load_ns_i` and the accumulator is cleared. A load takes priority over a wrap in the same edge. A loaded nanoseconds value must be below 1,000,000,000.
- R6: A new `addend_i` value is used from the next edge onward. Changing the addend does not clear or otherwise disturb the accumulated phase.
- R7: When `snap_i` is high at an edge, the holding registers take the time shown during the cycle before that edge. This is also true when a load happens in the same edge. While `snap_i` is low, the holding registers do not change.
- R8: With a step of 40 and an addend of 0x80000000 (a 20 ns clock), the time advances by exactly 40 ns on every second edge after a load. The nanoseconds read 0, 0, 40, 40, 80, … after edges 0, 1, 2, 3, 4, … following the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PTP reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addend_i | input | 32 | Frequency word added to the accumulator every cycle |
| incr_i | input | 8 | Nanoseconds added on each accumulator wrap |
| load_i | input | 1 | Load time and clear accumulator |
| load_sec_i | input | 32 | Seconds value to load |
| load_ns_i | input | 30 | Nanoseconds value to load (< 1e9) |
| snap_i | input | 1 | Capture the current time into the holding registers |
| sec_o | output | 32 | Running seconds |
| ns_o | output | 30 | Running nanoseconds |
| snap_sec_o | output | 32 | Captured seconds |
| snap_ns_o | output | 30 | Captured nanoseconds |

## Verification
The hardest case to reach from the ports is a phase residue left in the accumulator across an addend change. No output shows that residue directly.

The stimulus runs a segment with one addend and then switches to a second addend without reloading. The totals are chosen so that the number of wraps differs by one depending on whether the residue survives. A second case leaves the accumulator at half scale and then loads. The edge after the load must not advance, which shows the clear took effect.

The rate rule is covered by a sweep over a grid of addends and steps, with the expected time computed from the floor of the summed addends.

// File: rtl/ptp_tod_pkg.sv
// Package: shared time-of-day type and constants for the fine-adjust counter.
// Assumes nanoseconds never exceed one second minus one.
package ptp_tod_pkg;
    localparam int SEC_W = 32;
    localparam int NS_W  = 30;
    localparam int unsigned NS_PER_SEC = 32'd1_000_000_000;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;
endpackage

// File: rtl/ptp_frac_accum.sv
// Module: phase accumulator. Adds the frequency word every cycle and
// reports a wrap past 2^ACC_W as a one-cycle step request.
// Assumes the clear request wins over the add.
module ptp_frac_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [ACC_W-1:0] addend_i,
    output logic             step_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;

    // Purpose: form this cycle's sum and its wrap bit.
    always_comb begin
        {step_o, acc_sum} = {1'b0, acc_q} + {1'b0, addend_i};
    end

    // Purpose: hold the phase, clearing it on reset or load.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (clear_i) acc_q <= '0;
        else              acc_q <= acc_sum;
    end

    // R5: a load leaves the accumulator empty
    a_r5_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (acc_q == '0));
    // R2: a wrap leaves a smaller phase than before
    a_r2_wrap_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && step_o) |=> (acc_q < $past(acc_q)));
    // R2: no wrap means the phase did not fall
    a_r2_nowrap_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_o) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/ptp_tod_counter.sv
// Module: seconds/nanoseconds counter. Adds the step on each request and
// carries a full second into the seconds field. A load overrides stepping.
// Assumes loaded nanoseconds are below one second.
module ptp_tod_counter
    import ptp_tod_pkg::*;
#(
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  tod_t             load_val_i,
    input  logic             step_i,
    input  logic [INC_W-1:0] incr_i,
    output tod_t             tod_o
);
    localparam logic [NS_W:0] NS_LIMIT = (NS_W+1)'(NS_PER_SEC);

    tod_t          tod_q;
    tod_t          tod_adv;
    logic [NS_W:0] ns_sum;
    logic          sec_carry;

    // Purpose: compute the stepped time with nanosecond rollover.
    always_comb begin
        ns_sum      = {1'b0, tod_q.ns} + (NS_W+1)'(incr_i);
        sec_carry   = (ns_sum >= NS_LIMIT);
        tod_adv.sec = tod_q.sec + SEC_W'(sec_carry);
        tod_adv.ns  = sec_carry ? NS_W'(ns_sum - NS_LIMIT) : NS_W'(ns_sum);
    end

    // Purpose: register the time, with load priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)      tod_q <= '0;
        else if (load_i) tod_q <= load_val_i;
        else if (step_i) tod_q <= tod_adv;
    end

    assign tod_o = tod_q;

    // R5: load value appears after the edge
    a_r5_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (tod_q == $past(load_val_i)));
    // R2: time holds without a wrap
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(tod_q));
    // R3: nanoseconds stay inside one second
    a_r3_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, tod_q.ns} < NS_LIMIT));
    // R4: seconds move by zero or one
    a_r4_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ((tod_q.sec == $past(tod_q.sec)) ||
                     (tod_q.sec == $past(tod_q.sec) + SEC_W'(1))));
endmodule

// File: rtl/ptp_snap_reg.sv
// Module: holding registers that capture the running time on a strobe.
// Assumes the input is the registered time, so the copy is coherent.
module ptp_snap_reg
    import ptp_tod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic snap_i,
    input  tod_t tod_i,
    output tod_t snap_o
);
    tod_t snap_q;

    // Purpose: latch the time while the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)      snap_q <= '0;
        else if (snap_i) snap_q <= tod_i;
    end

    assign snap_o = snap_q;

    // R7: capture takes the pre-edge time
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_i |=> (snap_q == $past(tod_i)));
    // R7: no strobe, no change
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(snap_q));
endmodule

// File: rtl/ptp_fine_clock.sv
// Module: top of the fine-adjust PTP time counter. Joins the phase
// accumulator, the time counter and the capture registers.
// Assumes addend and step are held stable by a register block elsewhere.
module ptp_fine_clock
    import ptp_tod_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] addend_i,
    input  logic [INC_W-1:0] incr_i,
    input  logic             load_i,
    input  logic [SEC_W-1:0] load_sec_i,
    input  logic [NS_W-1:0]  load_ns_i,
    input  logic             snap_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [NS_W-1:0]  ns_o,
    output logic [SEC_W-1:0] snap_sec_o,
    output logic [NS_W-1:0]  snap_ns_o
);
    logic step;
    tod_t load_val;
    tod_t tod_now;
    tod_t tod_snap;

    assign load_val.sec = load_sec_i;
    assign load_val.ns  = load_ns_i;

    ptp_frac_accum #(.ACC_W(ACC_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (load_i),
        .addend_i (addend_i),
        .step_o   (step)
    );

    ptp_tod_counter #(.INC_W(INC_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .load_val_i (load_val),
        .step_i     (step),
        .incr_i     (incr_i),
        .tod_o      (tod_now)
    );

    ptp_snap_reg u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .snap_i (snap_i),
        .tod_i  (tod_now),
        .snap_o (tod_snap)
    );

    assign sec_o      = tod_now.sec;
    assign ns_o       = tod_now.ns;
    assign snap_sec_o = tod_snap.sec;
    assign snap_ns_o  = tod_snap.ns;
endmodule

// File: tb/tb_ptp_fine_clock.sv
module tb_ptp_fine_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addend_i = '0;
    logic [7:0]  incr_i = '0;
    logic        load_i = 1'b0;
    logic [31:0] load_sec_i = '0;
    logic [29:0] load_ns_i = '0;
    logic        snap_i = 1'b0;
    logic [31:0] sec_o, snap_sec_o;
    logic [29:0] ns_o, snap_ns_o;

    int tests = 0;
    int fails = 0;
    longint unsigned cum = 0, base_sec = 0, base_ns = 0;

    always #2 clk = ~clk;

    ptp_fine_clock dut (
        .clk(clk), .rst_n(rst_n), .addend_i(addend_i), .incr_i(incr_i),
        .load_i(load_i), .load_sec_i(load_sec_i), .load_ns_i(load_ns_i),
        .snap_i(snap_i), .sec_o(sec_o), .ns_o(ns_o),
        .snap_sec_o(snap_sec_o), .snap_ns_o(snap_ns_o)
    );

    task automatic chk(input string tag, input longint unsigned got, input longint unsigned exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            cum += addend_i;
        end
    endtask

    task automatic do_load(input longint unsigned s, input longint unsigned n);
        load_i = 1'b1; load_sec_i = 32'(s); load_ns_i = 30'(n);
        tick();
        load_i = 1'b0;
        cum = 0; base_sec = s; base_ns = n;
    endtask

    task automatic chk_model(input string tag);
        longint unsigned tot, es, en;
        tot = base_ns + (cum >> 32) * incr_i;
        es  = (base_sec + tot / 1_000_000_000) & 64'hFFFF_FFFF;
        en  = tot % 1_000_000_000;
        chk({tag, " sec"}, sec_o, es);
        chk({tag, " ns"}, ns_o, en);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] adds [7];
        logic [7:0]  incs [4];
        logic [31:0] cs;
        logic [29:0] cn;
        adds = '{32'h0, 32'h1, 32'h4000_0000, 32'h5555_5555,
                 32'h8000_0000, 32'hC000_0000, 32'hFFFF_FFFF};
        incs = '{8'd20, 8'd40, 8'd50, 8'd7};

        // R1: reset state
        repeat (3) tick();
        chk("R1 sec", sec_o, 0);       chk("R1 ns", ns_o, 0);
        chk("R1 snap sec", snap_sec_o, 0); chk("R1 snap ns", snap_ns_o, 0);
        rst_n = 1'b1;

        // R8: 40 ns every second edge at mid-range addend
        addend_i = 32'h8000_0000; incr_i = 8'd40;
        do_load(0, 0);
        for (int k = 1; k <= 8; k++) begin
            run(1);
            chk("R8 ns", ns_o, 40 * (k / 2));
        end

        // R2: sweep of addends and steps
        foreach (adds[a]) foreach (incs[s]) begin
            addend_i = adds[a]; incr_i = incs[s];
            do_load(3, 1000);
            run(37);
            chk_model("R2 sweep");
        end

        // R3: nanosecond rollover
        addend_i = 32'hFFFF_FFFF; incr_i = 8'd40;
        do_load(9, 999_999_980);
        run(2);
        chk("R3 sec", sec_o, 10); chk("R3 ns", ns_o, 20);

        // R4: seconds wrap
        addend_i = 32'h8000_0000;
        do_load(64'hFFFF_FFFF, 999_999_990);
        run(2);
        chk("R4 sec", sec_o, 0); chk("R4 ns", ns_o, 30);

        // R5: load wins over a wrap and clears the phase
        do_load(100, 0);
        run(1);
        do_load(200, 500);
        chk("R5 sec", sec_o, 200); chk("R5 ns", ns_o, 500);
        run(1);
        chk("R5 cleared ns", ns_o, 500);
        run(1);
        chk("R5 step ns", ns_o, 540);

        // R6: addend change keeps accumulated phase
        incr_i = 8'd50; addend_i = 32'h6000_0000;
        do_load(0, 0);
        run(3);
        chk("R6 seg1 ns", ns_o, 50);
        addend_i = 32'hA000_0000;
        run(3);
        chk("R6 seg2 ns", ns_o, 150);
        chk_model("R6 model");

        // R7: capture, hold, and capture during a load
        run(5);
        cs = sec_o; cn = ns_o;
        snap_i = 1'b1; run(1); snap_i = 1'b0;
        chk("R7 cap sec", snap_sec_o, cs); chk("R7 cap ns", snap_ns_o, cn);
        run(6);
        chk("R7 hold sec", snap_sec_o, cs); chk("R7 hold ns", snap_ns_o, cn);
        cs = sec_o; cn = ns_o;
        snap_i = 1'b1; do_load(77, 123); snap_i = 1'b0;
        chk("R7 load cap ns", snap_ns_o, cn); chk("R7 load cap sec", snap_sec_o, cs);
        chk("R7 load sec", sec_o, 77);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule